// File: doc/BRIEF.md
# Video Overlay Initialization Sequencer

This block owns the register-write port of an on-screen character display controller during bring-up. It issues a fixed series of mode writes, separated by settle intervals counted in milliseconds. The series passes through a short interlaced step before it commits non-interlaced scanning locked to the first field with 628 lines. Each interval is measured by a prescaled millisecond tick. While an interval runs, no write of any kind reaches the port.

Two modes are started from a single request. Cold start pulses the auto-clear output and waits a long boot interval. It then programs the level bits, the interlaced step, the first-field lock and the palette word. Sync switch first turns the display off, waits for the oscillator, and then runs the same interlaced step and lock. Both modes then open a setup window for the host. In that window the host loads the remaining registers, the sync RAM and the display RAM, in that order, through the same port. When the host ends the window, the sequencer writes display-on and pulses done. When the sequencer is idle, host writes pass straight through.

Top module: `ovlInitSeq`

## Requirements
- R1: After reset the block is idle: busy, done, hostWindow and wrEn are low, and autoClrN is high.
- R2: In cold start (modeSel=0), autoClrN is low for exactly ACLR_CYC cycles after the start request. No write is issued until at least MS_BOOT×CLK_PER_MS cycles after autoClrN returns high.
- R3: Cold start issues these writes in this order. First address A_LEVEL with data 0x05 (bit0 and bit2 set, bit1 clear). Then A_MODE with 0x03 (bit0 external-select and bit1 PAL-select set, bit2 non-interlace clear). Then A_MODE with 0x0F (bit2 non-interlace and bit3 628-line set). Then A_PALETTE with PAL_INIT. Last, after the setup window, A_DISP with 0x03 (both display-enable bits set).
- R4: Sync switch (modeSel=1) issues A_DISP 0x00, then A_MODE 0x03, then A_MODE 0x0F, then opens the window, then writes A_DISP 0x03. autoClrN stays high throughout.
- R5: The gap between two accepted sequencer writes is at least MS_OSC×CLK_PER_MS cycles after the level write, after the display-off write and after the palette write (the last measured to the opening of the window). The gap is at least MS_IL×CLK_PER_MS cycles after the interlaced-step write.
- R6: Host writes are forwarded only while idle or while hostWindow is high. Any host write at another time, including during every settle interval, never appears on wrEn.
- R7: wrEn is high only in a cycle where wrReady is high. Each sequencer write appears exactly once, however long wrReady is held low.
- R8: done is high for exactly one cycle, in the cycle after the display-on write is accepted. busy is low in that cycle.
- R9: A start request that arrives while busy is ignored, and the running sequence completes unchanged.
- R10: hostWindow stays high until setupDone is sampled. Host writes accepted in the window reach the port, and the display-on write follows the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a sequence (sampled while idle) |
| modeSel | input | 1 | 0 cold start, 1 sync switch |
| setupDone | input | 1 | Host ends the setup window |
| hostWrEn | input | 1 | Host write request |
| hostAddr | input | AW | Host write address |
| hostData | input | DW | Host write data |
| wrReady | input | 1 | Port accepts a write this cycle |
| wrEn | output | 1 | Single-cycle write strobe to the controller |
| wrAddr | output | AW | Write address |
| wrData | output | DW | Write data |
| autoClrN | output | 1 | Auto-clear, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| hostWindow | output | 1 | Host setup window open |

## Verification
The bench builds the block with CLK_PER_MS=3, boot, oscillator and interlace intervals of 6, 2 and 3 ticks, and ACLR_CYC=2. With these values a full sequence takes tens of cycles rather than millions. Many runs of both modes then fit in the budget, each with a random wrReady throttle and random host writes fired into every interval. The short prescaler also makes the restart of the tick counter at the start of each interval visible: a partial first tick would show up as a gap shorter than the bound.

// File: rtl/ovlSeqPkg.sv
package ovlSeqPkg;

  typedef enum logic [1:0] {
    WS_BOOT,
    WS_OSC,
    WS_IL
  } waitSel_e;

  typedef enum logic [2:0] {
    WR_LEVEL,
    WR_INTER,
    WR_LOCK,
    WR_PAL,
    WR_OFF,
    WR_ON
  } wrSel_e;

  typedef struct packed {
    logic     aclrLoad;
    logic     waitLoad;
    waitSel_e waitSel;
    logic     seqWr;
    wrSel_e   wrSel;
    logic     hostPass;
  } ctlStb_t;

  // field encodings decoded by the display controller
  localparam logic [3:0] LEVEL_BITS = 4'b0101;
  localparam logic [3:0] MODE_INTER = 4'b0011;
  localparam logic [3:0] MODE_LOCK  = 4'b1111;
  localparam logic [3:0] DISP_OFF   = 4'b0000;
  localparam logic [3:0] DISP_ON    = 4'b0011;

endpackage

// File: rtl/ovlMsTick.sv
module ovlMsTick #(
  parameter int CLK_PER_MS = 27000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (clear) begin
      preCnt <= '0;
    end else if (run) begin
      preCnt <= (preCnt == LAST) ? '0 : preCnt + 1'b1;
    end
  end

  assign tick = run && !clear && (preCnt == LAST);

  generate
    if (CLK_PER_MS > 1) begin : g_gapChk
      // R5: a restarted prescaler never yields back-to-back ticks
      a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ovlSeqData.sv
module ovlSeqData
  import ovlSeqPkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int CLK_PER_MS = 27000,
  parameter int MS_BOOT    = 200,
  parameter int MS_OSC     = 20,
  parameter int MS_IL      = 30,
  parameter int ACLR_CYC   = 16,
  parameter int A_LEVEL    = 1,
  parameter int A_MODE     = 2,
  parameter int A_PALETTE  = 3,
  parameter int A_DISP     = 4,
  parameter logic [DW-1:0] PAL_INIT = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStb_t       ctl,
  input  logic          hostWrEn,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  input  logic          wrReady,
  output logic          waitDone,
  output logic          aclrDone,
  output logic          wrEn,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData
);
  localparam int MS_MAX = (MS_BOOT > MS_OSC) ?
                          ((MS_BOOT > MS_IL) ? MS_BOOT : MS_IL) :
                          ((MS_OSC > MS_IL) ? MS_OSC : MS_IL);
  localparam int MSW = $clog2(MS_MAX + 1);
  localparam int ACW = $clog2(ACLR_CYC + 1);

  logic [MSW-1:0] waitCnt;
  logic [ACW-1:0] aclrCnt;
  logic           msTick;
  logic           waitRun;

  function automatic logic [MSW-1:0] waitLen(waitSel_e s);
    case (s)
      WS_BOOT: waitLen = MSW'(MS_BOOT);
      WS_OSC:  waitLen = MSW'(MS_OSC);
      default: waitLen = MSW'(MS_IL);
    endcase
  endfunction

  assign waitRun = (waitCnt != '0);

  ovlMsTick #(.CLK_PER_MS(CLK_PER_MS)) i_tick (
    .clk  (clk),
    .rstN (rstN),
    .clear(ctl.waitLoad),
    .run  (waitRun),
    .tick (msTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.waitLoad) begin
      waitCnt <= waitLen(ctl.waitSel);
    end else if (msTick) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aclrCnt <= '0;
    end else if (ctl.aclrLoad) begin
      aclrCnt <= ACW'(ACLR_CYC - 1);
    end else if (aclrCnt != '0) begin
      aclrCnt <= aclrCnt - 1'b1;
    end
  end

  assign waitDone = !waitRun;
  assign aclrDone = (aclrCnt == '0);

  always_comb begin
    wrEn   = 1'b0;
    wrAddr = hostAddr;
    wrData = hostData;
    if (ctl.seqWr) begin
      wrEn = 1'b1;
      case (ctl.wrSel)
        WR_LEVEL: begin wrAddr = AW'(A_LEVEL);   wrData = DW'(LEVEL_BITS); end
        WR_INTER: begin wrAddr = AW'(A_MODE);    wrData = DW'(MODE_INTER); end
        WR_LOCK:  begin wrAddr = AW'(A_MODE);    wrData = DW'(MODE_LOCK);  end
        WR_PAL:   begin wrAddr = AW'(A_PALETTE); wrData = PAL_INIT;        end
        WR_OFF:   begin wrAddr = AW'(A_DISP);    wrData = DW'(DISP_OFF);   end
        default:  begin wrAddr = AW'(A_DISP);    wrData = DW'(DISP_ON);    end
      endcase
    end else if (ctl.hostPass) begin
      wrEn = hostWrEn && wrReady;
    end
  end

  // R7: nothing leaves the port unless the port accepts it
  a_r7_ready_gate: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrReady);
  // R5: the control never strobes a write while an interval is counting
  a_r5_no_seq_write_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    waitRun |-> !ctl.seqWr);
  // R6: host traffic is never let through during an interval
  a_r6_no_pass_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    waitRun |-> !(wrEn && !ctl.seqWr));

endmodule

// File: rtl/ovlSeqCtrl.sv
module ovlSeqCtrl
  import ovlSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    modeSel,
  input  logic    setupDone,
  input  logic    wrReady,
  input  logic    waitDone,
  input  logic    aclrDone,
  output ctlStb_t ctl,
  output logic    busy,
  output logic    done,
  output logic    autoClrN,
  output logic    hostWindow
);
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACLR,
    ST_W_BOOT,
    ST_WR_LEVEL,
    ST_W_LEVEL,
    ST_WR_INTER,
    ST_W_INTER,
    ST_WR_LOCK,
    ST_WR_PAL,
    ST_W_PAL,
    ST_WR_OFF,
    ST_W_OFF,
    ST_HOST,
    ST_WR_ON
  } state_e;

  state_e state, stateNx;
  logic   syncMode, doneQ;

  always_comb begin
    stateNx  = state;
    ctl      = '0;
    ctl.wrSel   = WR_ON;
    ctl.waitSel = WS_OSC;
    unique case (state)
      ST_IDLE: begin
        ctl.hostPass = 1'b1;
        if (startReq) begin
          if (modeSel) begin
            stateNx = ST_WR_OFF;
          end else begin
            ctl.aclrLoad = 1'b1;
            stateNx = ST_ACLR;
          end
        end
      end
      ST_ACLR: if (aclrDone) begin
        ctl.waitLoad = 1'b1;
        ctl.waitSel  = WS_BOOT;
        stateNx = ST_W_BOOT;
      end
      ST_W_BOOT:  if (waitDone) stateNx = ST_WR_LEVEL;
      ST_WR_LEVEL: begin
        ctl.wrSel = WR_LEVEL;
        if (wrReady) begin
          ctl.seqWr    = 1'b1;
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = WS_OSC;
          stateNx = ST_W_LEVEL;
        end
      end
      ST_W_LEVEL: if (waitDone) stateNx = ST_WR_INTER;
      ST_WR_INTER: begin
        ctl.wrSel = WR_INTER;
        if (wrReady) begin
          ctl.seqWr    = 1'b1;
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = WS_IL;
          stateNx = ST_W_INTER;
        end
      end
      ST_W_INTER: if (waitDone) stateNx = ST_WR_LOCK;
      ST_WR_LOCK: begin
        ctl.wrSel = WR_LOCK;
        if (wrReady) begin
          ctl.seqWr = 1'b1;
          stateNx = syncMode ? ST_HOST : ST_WR_PAL;
        end
      end
      ST_WR_PAL: begin
        ctl.wrSel = WR_PAL;
        if (wrReady) begin
          ctl.seqWr    = 1'b1;
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = WS_OSC;
          stateNx = ST_W_PAL;
        end
      end
      ST_W_PAL: if (waitDone) stateNx = ST_HOST;
      ST_WR_OFF: begin
        ctl.wrSel = WR_OFF;
        if (wrReady) begin
          ctl.seqWr    = 1'b1;
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = WS_OSC;
          stateNx = ST_W_OFF;
        end
      end
      ST_W_OFF: if (waitDone) stateNx = ST_WR_INTER;
      ST_HOST: begin
        ctl.hostPass = 1'b1;
        if (setupDone) stateNx = ST_WR_ON;
      end
      ST_WR_ON: begin
        ctl.wrSel = WR_ON;
        if (wrReady) begin
          ctl.seqWr = 1'b1;
          stateNx = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      syncMode <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      state <= stateNx;
      doneQ <= (state == ST_WR_ON) && wrReady;
      if (state == ST_IDLE && startReq) syncMode <= modeSel;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = doneQ;
  assign autoClrN   = (state != ST_ACLR);
  assign hostWindow = (state == ST_HOST);

  // R8: completion is a single-cycle pulse seen only once idle again
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: a running sequence is not restarted by a new request
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && state != ST_WR_ON) |=> busy);
  // R10: the window only closes on the host's signal
  a_r10_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostWindow && !setupDone) |=> hostWindow);

endmodule

// File: rtl/ovlInitSeq.sv
module ovlInitSeq
  import ovlSeqPkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int CLK_PER_MS = 27000,
  parameter int MS_BOOT    = 200,
  parameter int MS_OSC     = 20,
  parameter int MS_IL      = 30,
  parameter int ACLR_CYC   = 16,
  parameter int A_LEVEL    = 1,
  parameter int A_MODE     = 2,
  parameter int A_PALETTE  = 3,
  parameter int A_DISP     = 4,
  parameter logic [DW-1:0] PAL_INIT = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          modeSel,
  input  logic          setupDone,
  input  logic          hostWrEn,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostData,
  input  logic          wrReady,
  output logic          wrEn,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          autoClrN,
  output logic          busy,
  output logic          done,
  output logic          hostWindow
);
  ctlStb_t ctl;
  logic    waitDone, aclrDone;

  ovlSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .modeSel   (modeSel),
    .setupDone (setupDone),
    .wrReady   (wrReady),
    .waitDone  (waitDone),
    .aclrDone  (aclrDone),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .autoClrN  (autoClrN),
    .hostWindow(hostWindow)
  );

  ovlSeqData #(
    .AW(AW), .DW(DW), .CLK_PER_MS(CLK_PER_MS),
    .MS_BOOT(MS_BOOT), .MS_OSC(MS_OSC), .MS_IL(MS_IL), .ACLR_CYC(ACLR_CYC),
    .A_LEVEL(A_LEVEL), .A_MODE(A_MODE), .A_PALETTE(A_PALETTE), .A_DISP(A_DISP),
    .PAL_INIT(PAL_INIT)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .hostWrEn(hostWrEn),
    .hostAddr(hostAddr),
    .hostData(hostData),
    .wrReady (wrReady),
    .waitDone(waitDone),
    .aclrDone(aclrDone),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  // R2: no write of any kind while auto-clear is held
  a_r2_quiet_in_aclr: assert property (@(posedge clk) disable iff (!rstN)
    !autoClrN |-> !wrEn);
  // R6: outside idle and the window only the sequencer drives the port
  a_r6_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hostWindow && wrEn) |-> (wrAddr == AW'(A_LEVEL) ||
      wrAddr == AW'(A_MODE) || wrAddr == AW'(A_PALETTE) || wrAddr == AW'(A_DISP)));

endmodule

// File: tb/test_ovlInitSeq.sv
module test_ovlInitSeq;
  localparam int AW = 4, DW = 8;
  localparam int CPM = 3, WB = 6, WO = 2, WI = 3, AC = 2;
  localparam logic [7:0] PALV = 8'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, startReq = 1'b0, modeSel = 1'b0, setupDone = 1'b0;
  logic hostWrEn = 1'b0, wrReady = 1'b1;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostData = '0;
  logic wrEn, autoClrN, busy, done, hostWindow;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  ovlInitSeq #(
    .AW(AW), .DW(DW), .CLK_PER_MS(CPM), .MS_BOOT(WB), .MS_OSC(WO),
    .MS_IL(WI), .ACLR_CYC(AC), .PAL_INIT(PALV)
  ) i_ovlInitSeq (.*);

  int nRun = 0, nFail = 0, cyc = 0;
  logic [3:0] lAddr [64];
  logic [7:0] lData [64];
  int lCyc [64];
  int nLog, aclrLow, aclrRise, doneCnt, doneRun, doneMax, doneBusy, doneCyc, winOpen;
  logic prevAclr = 1'b1, prevWin = 1'b0;
  bit readyRand = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    nLog = 0; aclrLow = 0; aclrRise = -1; doneCnt = 0; doneRun = 0;
    doneMax = 0; doneBusy = 0; doneCyc = -1; winOpen = -1;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (wrEn && nLog < 64) begin
        lAddr[nLog] = wrAddr; lData[nLog] = wrData; lCyc[nLog] = cyc; nLog++;
      end
      if (!autoClrN) aclrLow++;
      if (autoClrN && !prevAclr) aclrRise = cyc;
      if (hostWindow && !prevWin) winOpen = cyc;
      if (done) begin
        doneCnt++; doneRun++; doneCyc = cyc;
        if (busy) doneBusy++;
        if (doneRun > doneMax) doneMax = doneRun;
      end else doneRun = 0;
      prevAclr = autoClrN; prevWin = hostWindow;
    end
  end

  always @(posedge clk) begin
    #1;
    wrReady = readyRand ? ($urandom % 4 != 0) : 1'b1;
  end

  function automatic int expLen(bit m);
    return m ? 4 : 5;
  endfunction
  function automatic logic [3:0] expAddr(bit m, int i);
    if (m) return (i == 0 || i == 3) ? 4'd4 : 4'd2;
    case (i)
      0: return 4'd1;
      1, 2: return 4'd2;
      3: return 4'd3;
      default: return 4'd4;
    endcase
  endfunction
  function automatic logic [7:0] expData(bit m, int i);
    if (m) case (i)
      0: return 8'h00;
      1: return 8'h03;
      2: return 8'h0F;
      default: return 8'h03;
    endcase
    case (i)
      0: return 8'h05;
      1: return 8'h03;
      2: return 8'h0F;
      3: return PALV;
      default: return 8'h03;
    endcase
  endfunction

  task automatic runSeq(bit m, bit rr);
    int t = 0, winCyc = 0, nSeq = 0, nWin = 0, stray = 0, early = 0;
    int sc [8];
    clearLog();
    readyRand = rr;
    @(posedge clk); #1 startReq = 1'b1; modeSel = m;
    @(posedge clk); #1 startReq = 1'b0;
    repeat (4) @(posedge clk);
    #1 startReq = 1'b1; modeSel = ~m;      // R9: must be ignored
    @(posedge clk); #1 startReq = 1'b0;
    while (doneCnt == 0 && t < 20000) begin
      @(posedge clk); #1; t++;
      setupDone = 1'b0; hostWrEn = 1'b0;
      if (hostWindow) begin
        winCyc++;
        if (winCyc < 8) begin
          hostWrEn = 1'b1; hostAddr = 4'hD; hostData = 8'(winCyc);
        end else if (winCyc == 8) setupDone = 1'b1;
      end else if (busy) begin
        hostWrEn = ($urandom % 3 == 0); hostAddr = 4'hE; hostData = 8'($urandom);
      end
    end
    hostWrEn = 1'b0; setupDone = 1'b0; readyRand = 1'b0;
    @(negedge clk);
    chk(t < 20000, "WDOG", t, 0);
    for (int i = 0; i < nLog; i++) begin
      if (lAddr[i] == 4'hE) stray++;
      else if (lAddr[i] == 4'hD) begin
        nWin++;
        if (winOpen < 0 || lCyc[i] < winOpen) early++;
      end else begin
        if (nSeq < 8) sc[nSeq] = lCyc[i];
        if (nSeq < expLen(m)) begin
          chk(lAddr[i] == expAddr(m, nSeq), m ? "R4 addr" : "R3 addr",
              int'(lAddr[i]), int'(expAddr(m, nSeq)));
          chk(lData[i] == expData(m, nSeq), m ? "R4 data" : "R3 data",
              int'(lData[i]), int'(expData(m, nSeq)));
        end
        nSeq++;
      end
    end
    chk(nSeq == expLen(m), "R9 sequence count (second start ignored)", nSeq, expLen(m));
    chk(stray == 0, "R6 blocked host writes", stray, 0);
    chk(nWin > 0 && early == 0, "R10 window writes", nWin, 1);
    chk(doneCnt == 1 && doneMax == 1 && doneBusy == 0, "R8 done pulse", doneCnt, 1);
    if (nSeq >= expLen(m)) begin
      chk(doneCyc == sc[expLen(m)-1] + 1, "R8 done timing", doneCyc, sc[expLen(m)-1] + 1);
      chk(sc[expLen(m)-1] > winOpen, "R10 display-on after window", sc[expLen(m)-1], winOpen);
      chk(sc[1] - sc[0] >= WO * CPM, "R5 oscillator gap", sc[1] - sc[0], WO * CPM);
      chk(sc[2] - sc[1] >= WI * CPM, "R5 interlace gap", sc[2] - sc[1], WI * CPM);
      if (!m) begin
        chk(aclrLow == AC, "R2 auto-clear width", aclrLow, AC);
        chk(sc[0] - aclrRise >= WB * CPM, "R2 boot wait", sc[0] - aclrRise, WB * CPM);
        chk(winOpen - sc[3] >= WO * CPM, "R5 palette gap", winOpen - sc[3], WO * CPM);
      end else begin
        chk(aclrLow == 0, "R4 auto-clear untouched", aclrLow, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !hostWindow && !wrEn && autoClrN, "R1 reset state",
        {busy, done, hostWindow, wrEn, autoClrN}, 1);
    // R6: idle passes host writes straight through
    @(posedge clk); #1 hostWrEn = 1'b1; hostAddr = 4'hC; hostData = 8'h77;
    @(negedge clk);
    chk(wrEn && wrAddr == 4'hC && wrData == 8'h77, "R6 idle forward", int'(wrAddr), 12);
    @(posedge clk); #1 hostWrEn = 1'b0;
    runSeq(1'b0, 1'b0);
    runSeq(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) runSeq(k[0], 1'b1);  // R7 throttled ready
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nRun++; nFail++;
    $display("FAIL WDOG global timeout act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule